// File: doc/BRIEF.md
# Acquisition Event Buffer with Serial Readout

This block records processed bunch-crossing events into a 96-word, 72-bit store while an acquisition window is open. It then returns the stored words one bit at a time once the window has closed. The acquisition window is set by a level input, the shutter. Opening the shutter starts a fresh acquisition: the store is emptied, the crossing counter restarts and the read position goes back to the start. While the shutter stays high, each event strobe is one sample cycle. The event is packed into a word whose layout depends on a 2-bit processing mode and is tagged with the crossing number. The word is saved only if it carries data. When the store is full, later events are dropped and the stored words are left as they are.

When the shutter is low, an external readout clock steps the serial output. That clock is sampled in the system clock domain. Each falling edge advances one bit, from the top bit of the oldest word down to bit 0, and then on to the next word. Word slots that were never written read as zeros. An empty flag lets the controlling system tell whether the last acquisition saved anything at all.

Top module: `acq_event_buffer`

## Requirements
- R1: A shutter rising edge, seen on the system clock, starts an acquisition. It empties the store, raises the empty flag, sets the crossing counter to 0 and moves the read position to bit 71 of word 0.
- R2: A word is written only on a clock where `evt_valid` is high, the shutter is high and was also high on the previous clock, and the mode's payload field is nonzero. Mode codes: 00 stub, 01 pass-through with no storage, 10 centroid, 11 raw hits. Mode 01 never writes.
- R3: At most 96 words are stored per acquisition. Events after the 96th stored word are discarded, and words already stored are not changed.
- R4: Stub mode word: bits 51:0 are payload bits 51:0 (four 13-bit stubs), bits 67:52 are the crossing number, and bits 71:68 are all ones. The word is stored when payload bits 51:0 are nonzero.
- R5: Raw mode word: bits 47:0 are payload bits 47:0 (48 hit bits), bits 63:48 are the crossing number, and bits 71:64 are all ones. The word is stored when payload bits 47:0 are nonzero.
- R6: Centroid mode word: bits 55:0 are the 56-bit payload (eight 7-bit centroids), bits 71:56 are the crossing number, and there are no header ones. The word is stored when the payload is nonzero.
- R7: `empty` is 1 after reset and after each acquisition start. It goes to 0 on the clock edge that writes the first word.
- R8: The crossing number of an event equals the count of earlier event strobes in the same acquisition, whether or not those events were stored, taken modulo 2^16.
- R9: While the shutter is low, `serial_out` shows the bit at the read position. Each falling edge of `rd_clk` moves the position down one bit. After bit 0 of a word, the position moves to bit 71 of the next word. `serial_out` updates one system clock after the edge is sampled.
- R10: Word slots that were not written read as zeros. After 6912 falling edges, `serial_out` stays at 0.
- R11: Edges on `rd_clk` while the shutter is high do not move the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shutter | input | 1 | High: acquire; low: read out |
| evt_valid | input | 1 | Sample-cycle event strobe |
| evt_mode | input | 2 | Processing mode code for the event |
| evt_payload | input | 56 | Event payload; field use depends on mode |
| rd_clk | input | 1 | External readout clock, sampled on clk |
| empty | output | 1 | No word stored in this acquisition |
| serial_out | output | 1 | Serial readout bit |

## Verification
A wrong write count or a wrong write address shows up as a misplaced or missing word in the serial stream. It also shows as a word carrying the wrong crossing number, which can be seen only after the shutter closes and readout reaches that word. A read pointer that drifts, whether from edges taken during acquisition or a bad word carry, corrupts every later bit, so the first wrong bit points to the fault. A wrong empty flag can be seen on the clock after the first data-carrying event. Crossing-number wrap is checked at the 65535-to-0 boundary.

// File: rtl/acqbuf_pkg.sv
package acqbuf_pkg;

    localparam int WORD_W     = 72;
    localparam int BX_W       = 16;
    localparam int STUB_W     = 13;
    localparam int N_STUB     = 4;
    localparam int CENT_W     = 7;
    localparam int N_CENT     = 8;
    localparam int N_HIT      = 48;
    localparam int PAY_W      = N_CENT * CENT_W;
    localparam int STUB_BITS  = N_STUB * STUB_W;
    localparam int HDR_STUB   = WORD_W - BX_W - STUB_BITS;
    localparam int HDR_RAW    = WORD_W - BX_W - N_HIT;

    typedef enum logic [1:0] {
        MODE_STUB = 2'b00,
        MODE_NONE = 2'b01,
        MODE_CENT = 2'b10,
        MODE_RAW  = 2'b11
    } acq_mode_e;

    typedef struct packed {
        logic              keep;
        logic [WORD_W-1:0] data;
    } fmt_word_t;

    function automatic fmt_word_t pack_event(
        input logic [1:0]       mode,
        input logic [PAY_W-1:0] pay,
        input logic [BX_W-1:0]  bx
    );
        fmt_word_t r;
        r.keep = 1'b0;
        r.data = '0;
        case (acq_mode_e'(mode))
            MODE_STUB: begin
                r.keep = |pay[STUB_BITS-1:0];
                r.data = {{HDR_STUB{1'b1}}, bx, pay[STUB_BITS-1:0]};
            end
            MODE_RAW: begin
                r.keep = |pay[N_HIT-1:0];
                r.data = {{HDR_RAW{1'b1}}, bx, pay[N_HIT-1:0]};
            end
            MODE_CENT: begin
                r.keep = |pay;
                r.data = {bx, pay};
            end
            default: begin
                r.keep = 1'b0;
                r.data = '0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/acqbuf_ctrl.sv
module acqbuf_ctrl
    import acqbuf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            shutter,
    input  logic            evt_valid,
    input  logic            wr_done,
    output logic            acq_start,
    output logic            acq_on,
    output logic [BX_W-1:0] bx,
    output logic            empty
);

    logic shut_q;

    always_ff @(posedge clk) begin
        if (rst) shut_q <= 1'b0;
        else     shut_q <= shutter;
    end

    assign acq_start = shutter & ~shut_q;
    assign acq_on    = shutter & shut_q;

    always_ff @(posedge clk) begin
        if (rst || acq_start)        bx <= '0;
        else if (acq_on && evt_valid) bx <= bx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || acq_start) empty <= 1'b1;
        else if (wr_done)     empty <= 1'b0;
    end

    AST_BX_RESTART: assert property (@(posedge clk) disable iff (rst)
        acq_start |=> (bx == '0)); // R8

    AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (rst)
        $fell(empty) |-> $past(wr_done)); // R7

    AST_EMPTY_SET: assert property (@(posedge clk) disable iff (rst)
        acq_start |=> empty); // R1

endmodule

// File: rtl/acqbuf_store.sv
module acqbuf_store
    import acqbuf_pkg::*;
#(
    parameter int DEPTH = 96,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(DEPTH)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_req,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [CW-1:0]     rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic              wr_done
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [CW-1:0]     count;
    logic              full;

    assign full    = (count == CW'(DEPTH));
    assign wr_done = wr_req & ~full & ~clear;

    always_ff @(posedge clk) begin
        if (rst || clear)  count <= '0;
        else if (wr_done)  count <= count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_done) mem[count[IW-1:0]] <= wr_word;
    end

    assign rd_word = (rd_idx < count) ? mem[rd_idx[IW-1:0]] : '0;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)); // R3

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (full && !clear) |=> full); // R3

    AST_CLEAR_COUNT: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count == '0)); // R1

endmodule

// File: rtl/acqbuf_reader.sv
module acqbuf_reader
    import acqbuf_pkg::*;
#(
    parameter int DEPTH = 96,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int BW = $clog2(WORD_W)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          shutter,
    input  logic          rd_clk,
    output logic [CW-1:0] widx,
    output logic [BW-1:0] bsel
);

    logic rd_prev;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) rd_prev <= 1'b1;
        else     rd_prev <= rd_clk;
    end

    assign fall = rd_prev & ~rd_clk & ~shutter;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            widx <= '0;
            bsel <= BW'(WORD_W - 1);
        end else if (fall && widx < CW'(DEPTH)) begin
            if (bsel == '0) begin
                widx <= widx + 1'b1;
                bsel <= BW'(WORD_W - 1);
            end else begin
                bsel <= bsel - 1'b1;
            end
        end
    end

    AST_RD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (shutter && !restart) |=> $stable({widx, bsel})); // R11

    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        bsel < BW'(WORD_W)); // R9

    AST_END_HOLD: assert property (@(posedge clk) disable iff (rst)
        (widx == CW'(DEPTH) && !restart) |=> (widx == CW'(DEPTH))); // R10

endmodule

// File: rtl/acq_event_buffer.sv
module acq_event_buffer
    import acqbuf_pkg::*;
#(
    parameter int DEPTH = 96,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int BW = $clog2(WORD_W)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             shutter,
    input  logic             evt_valid,
    input  logic [1:0]       evt_mode,
    input  logic [PAY_W-1:0] evt_payload,
    input  logic             rd_clk,
    output logic             empty,
    output logic             serial_out
);

    logic              acq_start;
    logic              acq_on;
    logic [BX_W-1:0]   bx;
    logic              wr_done;
    logic              wr_req;
    fmt_word_t         fw;
    logic [CW-1:0]     widx;
    logic [BW-1:0]     bsel;
    logic [WORD_W-1:0] rd_word;

    acqbuf_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .shutter   (shutter),
        .evt_valid (evt_valid),
        .wr_done   (wr_done),
        .acq_start (acq_start),
        .acq_on    (acq_on),
        .bx        (bx),
        .empty     (empty)
    );

    assign fw     = pack_event(evt_mode, evt_payload, bx);
    assign wr_req = acq_on & evt_valid & fw.keep;

    acqbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clear   (acq_start),
        .wr_req  (wr_req),
        .wr_word (fw.data),
        .rd_idx  (widx),
        .rd_word (rd_word),
        .wr_done (wr_done)
    );

    acqbuf_reader #(.DEPTH(DEPTH)) u_reader (
        .clk     (clk),
        .rst     (rst),
        .restart (acq_start),
        .shutter (shutter),
        .rd_clk  (rd_clk),
        .widx    (widx),
        .bsel    (bsel)
    );

    assign serial_out = rd_word[bsel];

    AST_NO_WRITE_CLOSED: assert property (@(posedge clk) disable iff (rst)
        !shutter |-> !wr_done); // R2

endmodule

// File: tb/tb_acq_event_buffer.sv
module tb_acq_event_buffer;
    import acqbuf_pkg::*;

    localparam int DEPTH = 96;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             shutter = 1'b0;
    logic             evt_valid = 1'b0;
    logic [1:0]       evt_mode = 2'b00;
    logic [PAY_W-1:0] evt_payload = '0;
    logic             rd_clk = 1'b1;
    logic             empty;
    logic             serial_out;

    int total = 0;
    int bad = 0;

    logic [WORD_W-1:0] exp_mem [DEPTH];
    string             exp_req [DEPTH];
    int                exp_cnt = 0;
    int                exp_bx = 0;

    always #2.5 clk = ~clk;

    acq_event_buffer #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .shutter(shutter), .evt_valid(evt_valid),
        .evt_mode(evt_mode), .evt_payload(evt_payload), .rd_clk(rd_clk),
        .empty(empty), .serial_out(serial_out)
    );

    task automatic check(input string req, input logic [WORD_W-1:0] got,
                         input logic [WORD_W-1:0] want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, want);
        end
    endtask

    task automatic open_acq();
        @(negedge clk) shutter = 1'b1;
        @(negedge clk);
        exp_cnt = 0;
        exp_bx  = 0;
        check("R1 R7 empty at start", {71'd0, empty}, 72'd1);
    endtask

    task automatic close_acq();
        rd_clk = 1'b1;
        @(negedge clk) shutter = 1'b0;
        @(negedge clk);
    endtask

    // one-cycle event; model per R2 R3 R4 R5 R6 R8
    task automatic ev(input logic [1:0] m, input logic [PAY_W-1:0] p);
        logic [WORD_W-1:0] w;
        logic              keep;
        logic [15:0]       b;
        evt_valid   = 1'b1;
        evt_mode    = m;
        evt_payload = p;
        b    = 16'(exp_bx);
        keep = 1'b0;
        w    = '0;
        if (shutter) begin
            if (m == 2'b00) begin
                keep = (p[51:0] != 0);
                w = (72'hF << 68) | (72'(b) << 52) | 72'(p[51:0]);
            end else if (m == 2'b11) begin
                keep = (p[47:0] != 0);
                w = (72'hFF << 64) | (72'(b) << 48) | 72'(p[47:0]);
            end else if (m == 2'b10) begin
                keep = (p != 0);
                w = (72'(b) << 56) | 72'(p);
            end
            if (keep && exp_cnt < DEPTH) begin
                exp_mem[exp_cnt] = w;
                exp_req[exp_cnt] = (m == 2'b00) ? "R4 R8" :
                                   (m == 2'b11) ? "R5 R8" : "R6 R8";
                exp_cnt++;
            end
            exp_bx = (exp_bx + 1) % 65536;
        end
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic fall_pulse();
        rd_clk = 1'b0;
        @(negedge clk);
        rd_clk = 1'b1;
        @(negedge clk);
    endtask

    // read nw words serially and compare (R9 order, R10 zeros, R3 content)
    task automatic read_words(input int nw);
        logic [WORD_W-1:0] got;
        for (int w = 0; w < nw; w++) begin
            for (int b = WORD_W - 1; b >= 0; b--) begin
                got[b] = serial_out;
                fall_pulse();
            end
            if (w < exp_cnt) check({exp_req[w], " R9 R3"}, got, exp_mem[w]);
            else             check("R10 R2 unwritten word", got, '0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R7 reset empty", {71'd0, empty}, 72'd1);
        check("R10 reset serial", {71'd0, serial_out}, 72'd0);

        // Acquisition A: mixed modes, empty events, ignored clock edges
        open_acq();
        for (int i = 0; i < 10; i++) begin
            rd_clk = ~rd_clk;           // R11: ignored during acquisition
            @(negedge clk);
        end
        rd_clk = 1'b1;
        ev(2'b00, '0);
        check("R7 empty after empty event", {71'd0, empty}, 72'd1);
        ev(2'b00, 56'h0_0000_0000_0001 << 13);
        check("R7 empty after first write", {71'd0, empty}, 72'd0);
        ev(2'b01, 56'hFF_FFFF_FFFF_FFFF);   // R2: mode 01 never stores
        ev(2'b11, 56'hF0_0000_0000_0000);   // R5: bits above 47 only -> no store
        ev(2'b11, 56'h00_8000_0000_0001);
        ev(2'b10, 56'h80_0000_0000_0000);
        ev(2'b00, 56'hF0_0000_0000_0000);   // R4: bits above 51 only -> no store
        for (int i = 0; i < 8; i++)
            ev(2'(i % 4), 56'(64'h1 << (i * 7)) | 56'h3);
        close_acq();
        ev(2'b11, 56'h1);                   // R2: shutter low, not stored
        check("R11 first bit after acq edges", {71'd0, serial_out},
              {71'd0, exp_mem[0][71]});
        read_words(DEPTH);
        for (int i = 0; i < 3; i++) begin
            check("R10 hold zero after end", {71'd0, serial_out}, 72'd0);
            fall_pulse();
        end

        // Acquisition B: overflow, R3, restart R1
        open_acq();
        for (int i = 0; i < DEPTH + 14; i++)
            ev(2'b11, 56'(i + 1));
        close_acq();
        read_words(DEPTH);

        // Acquisition C: crossing number wrap, partial readout
        open_acq();
        for (int i = 0; i < 65538; i++)
            ev(2'b10, (i == 3 || i == 65535 || i == 65536) ? 56'h5A : 56'h0);
        close_acq();
        read_words(3);

        // Acquisition D: restart after partial readout
        open_acq();
        ev(2'b00, 56'h1);
        close_acq();
        read_words(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired got=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule